// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles, using the shift-and-subtract restoring method. A single combined register holds the partial remainder in its upper part and the dividend, then the quotient, in its lower part. One quotient bit is produced per cycle. Each cycle the divisor is trial-subtracted from the upper part. If the difference is not negative, it is kept and a 1 enters at the low end. Otherwise the old partial remainder is kept and a 0 enters.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` then stays high while the loop runs. `done` pulses once when the quotient and remainder are ready on the outputs. The results stay on the outputs until the next accepted `start`. The upper register part is one bit wider than the operands, so divisors with the top bit set are handled correctly. Dividing by zero gives a fixed result and takes the same number of cycles as any other division.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `quo_lo` and `rem_hi` are 0.
- R2: A `start` pulse sampled while `busy` is 0 is accepted. `busy` is 1 from the next cycle for exactly WIDTH cycles.
- R3: `done` is 1 for exactly one cycle, WIDTH+1 cycles after the clock edge that accepted `start`. `busy` is 0 in that cycle.
- R4: When `done` is 1 and the divisor is nonzero, `quo_lo` equals the unsigned floor of dividend / divisor. This includes operands whose most significant bit is set.
- R5: When `done` is 1 and the divisor is nonzero, `rem_hi` equals dividend modulo divisor, which is always less than the divisor.
- R6: A zero divisor gives `quo_lo` with all bits 1 and `rem_hi` equal to the dividend, with the same latency as R3.
- R7: A `start` pulse sampled while `busy` is 1 is ignored. The running division finishes at its original time with results for its original operands.
- R8: After `done`, `quo_lo` and `rem_hi` hold their values until the next accepted `start`.
- R9: Operands are sampled only on the accepting edge. Changes on `dividend` and `divisor` during the run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only when idle |
| dividend | input | WIDTH | Unsigned numerator |
| divisor | input | WIDTH | Unsigned denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quo_lo | output | WIDTH | Quotient |
| rem_hi | output | WIDTH | Remainder |

## Verification
A wrong quotient bit decision in any iteration gives a wrong quotient and remainder at the `done` pulse. Such a fault cannot hide until later: that pulse is only WIDTH+1 cycles after the start. A narrow sweep over every operand pair of a small width reaches every compare outcome. That includes remainders that overflow the operand width before the compare, which only appear with large divisors. A miscounted loop counter shows as `done` arriving in the wrong cycle. A register loaded at the wrong time shows as results that follow a start issued while busy, or follow operands changed in mid-run.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

   // Width of a down-counter that must hold the value n.
   function automatic int count_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/seqdiv_step.sv
// One restoring iteration: trial subtract, sign test, keep or restore.
module seqdiv_step #(
   parameter int WIDTH       = 32,
   parameter bit RESTORE_ADD = 1'b0
) (
   input  logic [WIDTH:0]   part_in,
   input  logic [WIDTH-1:0] dsr,
   output logic [WIDTH:0]   part_out,
   output logic             q_bit
);
   localparam int DW = WIDTH + 2;

   logic [DW-1:0] diff;
   logic          negative;

   assign diff     = {1'b0, part_in} - {2'b00, dsr};
   assign negative = diff[DW-1];
   assign q_bit    = ~negative;

   generate
      if (RESTORE_ADD) begin : g_add_back
         logic [DW-1:0] restored;
         assign restored = diff + {2'b00, dsr};
         assign part_out = negative ? restored[WIDTH:0] : diff[WIDTH:0];
      end else begin : g_select
         assign part_out = negative ? part_in : diff[WIDTH:0];
      end
   endgenerate

endmodule

// File: rtl/seqdiv_ctrl.sv
// Iteration counter and handshake for the divider.
module seqdiv_ctrl
   import seqdiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CW = count_bits(WIDTH);
   localparam logic [CW-1:0] ITERS = CW'(WIDTH);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load = start & ~busy_q;
   assign step = busy_q;
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            cnt_q  <= ITERS;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);                                   // R3
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);                                   // R3
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);                             // R2
   AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0));                             // R2

endmodule

// File: rtl/seq_restoring_div.sv
// Multi-cycle unsigned restoring divider, one quotient bit per cycle.
module seq_restoring_div #(
   parameter int WIDTH       = 32,
   parameter bit RESTORE_ADD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quo_lo,
   output logic [WIDTH-1:0] rem_hi
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_restoring_div: WIDTH must be at least 2");
      end
   endgenerate

   logic             load;
   logic             step;
   logic [WIDTH:0]   part_q;   // partial remainder, one extra bit
   logic [WIDTH-1:0] low_q;    // dividend bits, then quotient bits
   logic [WIDTH-1:0] dsr_q;
   logic [WIDTH:0]   part_nxt;
   logic             q_bit;

   seqdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   seqdiv_step #(.WIDTH(WIDTH), .RESTORE_ADD(RESTORE_ADD)) u_step (
      .part_in  (part_q),
      .dsr      (dsr_q),
      .part_out (part_nxt),
      .q_bit    (q_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         low_q  <= '0;
         dsr_q  <= '0;
      end else if (load) begin
         // dividend enters the low part, whole register shifted left once
         part_q <= {{WIDTH{1'b0}}, dividend[WIDTH-1]};
         low_q  <= {dividend[WIDTH-2:0], 1'b0};
         dsr_q  <= divisor;
      end else if (step) begin
         part_q <= {part_nxt[WIDTH-1:0], low_q[WIDTH-1]};
         low_q  <= {low_q[WIDTH-2:0], q_bit};
      end
   end

   assign quo_lo = low_q;
   assign rem_hi = part_q[WIDTH:1];   // undo the last shift of the upper part

   AST_PARTIAL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !part_nxt[WIDTH]);                            // R4
   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dsr_q != '0) |-> (rem_hi < dsr_q));           // R5
   AST_ZERO_DIV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dsr_q == '0) |-> (quo_lo == '1));             // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(dsr_q));                   // R7
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quo_lo) && $stable(rem_hi))); // R8

endmodule

// File: tb/seq_restoring_div_bench.sv
`timescale 1ns/1ps
module seq_restoring_div_bench;
   localparam int SW = 6;
   localparam int LW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          s_start = 1'b0;
   logic [SW-1:0] s_a = '0, s_b = '0;
   logic          s_busy, s_done;
   logic [SW-1:0] s_q, s_r;

   logic          w_start = 1'b0;
   logic [LW-1:0] w_a = '0, w_b = '0;
   logic          w_busy, w_done;
   logic [LW-1:0] w_q, w_r;

   int checks = 0;
   int errors = 0;

   seq_restoring_div #(.WIDTH(SW), .RESTORE_ADD(1'b0)) u_seq_restoring_div (
      .clk(clk), .rst_n(rst_n), .start(s_start), .dividend(s_a), .divisor(s_b),
      .busy(s_busy), .done(s_done), .quo_lo(s_q), .rem_hi(s_r));

   seq_restoring_div #(.WIDTH(LW), .RESTORE_ADD(1'b1)) u_seq_restoring_div_w32 (
      .clk(clk), .rst_n(rst_n), .start(w_start), .dividend(w_a), .divisor(w_b),
      .busy(w_busy), .done(w_done), .quo_lo(w_q), .rem_hi(w_r));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one division; mid-run disturbances optional (R7, R9).
   task automatic run(input bit wide, input logic [31:0] a, input logic [31:0] b,
                      input bit disturb, output logic [31:0] q, output logic [31:0] r,
                      output int lat);
      int n;
      @(negedge clk);
      if (wide) begin w_a = a; w_b = b; w_start = 1'b1; end
      else begin s_a = a[SW-1:0]; s_b = b[SW-1:0]; s_start = 1'b1; end
      @(negedge clk);
      n = 1;
      if (wide) w_start = 1'b0; else s_start = 1'b0;
      check("R2 busy after start", wide ? w_busy : s_busy, 1);
      while (!(wide ? w_done : s_done) && n < 200) begin
         if (disturb && n == 2) begin
            if (wide) begin w_start = 1'b1; w_a = ~a; w_b = a ^ 32'h5; end
            else begin s_start = 1'b1; s_a = ~a[SW-1:0]; s_b = a[SW-1:0] ^ 6'h5; end
         end else begin
            if (wide) w_start = 1'b0; else s_start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      if (wide) w_start = 1'b0; else s_start = 1'b0;
      lat = n;
      q = wide ? w_q : 32'(s_q);
      r = wide ? w_r : 32'(s_r);
      check("R3 busy low at done", wide ? w_busy : s_busy, 0);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] q, r, eq, er;
      int lat;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", s_busy, 0);
      check("R1 done", s_done, 0);
      check("R1 quo", w_q, 0);
      check("R1 rem", w_r, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Exhaustive sweep on the narrow instance: R4 R5 R6 R3
      for (int a = 0; a < (1 << SW); a++) begin
         for (int b = 0; b < (1 << SW); b++) begin
            run(1'b0, 32'(a), 32'(b), 1'b0, q, r, lat);
            if (b == 0) begin
               check("R6 zero divisor quo", q, 32'((1 << SW) - 1));
               check("R6 zero divisor rem", r, 32'(a));
               check("R6 zero divisor latency", 32'(lat), SW + 1);
            end else begin
               check("R4 quotient", q, 32'(a / b));
               check("R5 remainder", r, 32'(a % b));
               check("R3 latency", 32'(lat), SW + 1);
            end
         end
      end

      // Wide directed cases including MSB-set operands
      for (int i = 0; i < 8; i++) begin
         logic [31:0] a, b;
         case (i)
            0: begin a = 32'hFFFF_FFFF; b = 32'h8000_0001; end
            1: begin a = 32'hFFFF_FFFF; b = 32'h0000_0001; end
            2: begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
            3: begin a = 32'hDEAD_BEEF; b = 32'h0000_1234; end
            4: begin a = 32'h0000_0007; b = 32'h0000_0009; end
            5: begin a = 32'hF000_0000; b = 32'hE000_0000; end
            6: begin a = 32'h1234_5678; b = 32'h0000_0000; end
            default: begin a = 32'hFFFF_FFFE; b = 32'hFFFF_FFFF; end
         endcase
         run(1'b1, a, b, 1'b0, q, r, lat);
         eq = (b == 0) ? 32'hFFFF_FFFF : a / b;
         er = (b == 0) ? a : a % b;
         check(b == 0 ? "R6 wide quo" : "R4 wide quotient", q, eq);
         check(b == 0 ? "R6 wide rem" : "R5 wide remainder", r, er);
         check("R3 wide latency", 32'(lat), LW + 1);
      end

      // R7 and R9: start pulse and operand changes during a run
      run(1'b1, 32'hC0DE_F00D, 32'h0001_0003, 1'b1, q, r, lat);
      check("R7 R9 wide quotient", q, 32'hC0DE_F00D / 32'h0001_0003);
      check("R7 R9 wide remainder", r, 32'hC0DE_F00D % 32'h0001_0003);
      check("R7 latency unchanged", 32'(lat), LW + 1);
      run(1'b0, 32'd61, 32'd7, 1'b1, q, r, lat);
      check("R7 R9 narrow quotient", q, 32'd8);
      check("R7 R9 narrow remainder", r, 32'd5);

      // R8: results held and done gone while idle, inputs changing
      @(negedge clk);
      check("R3 done single cycle", s_done, 0);
      s_a = 6'h3F; s_b = 6'h01;
      w_a = 32'h1; w_b = 32'h1;
      repeat (4) @(negedge clk);
      check("R8 narrow quotient held", s_q, 8);
      check("R8 narrow remainder held", s_r, 5);
      check("R8 wide quotient held", w_q, 32'hC0DE_F00D / 32'h0001_0003);
      check("R8 busy stays low", w_busy, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule